// File: doc/BRIEF.md
# Signaling Channel Change Detector

This block watches the upstream control and signaling channels of a time-slot interface. Each cycle it may receive one channel, given as a channel address and an 8-bit code. It compares the code with the value held for that channel in a control memory. When a change is confirmed, the new value is written into the memory, the channel address is queued in a small address FIFO, and an interrupt is raised. Software drains the FIFO one address per read and can read any channel's stored value by address.

Three signaling schemes are supported. In the control/indication scheme only a 4-bit indication field counts, and a change is taken as soon as it arrives. In the 6-bit and 8-bit schemes a double last look filter is applied. A 7-bit programmable timer divides time into look periods. A channel's first arrival in each period is its look. A new value is accepted only when two consecutive looks of that channel return the same value.

Top module: `sig_change_top`

## Requirements
- R1: `scheme` selects the field that is compared and stored: 0 uses bits [3:0] (the indication field; the upper bits, D bits included, are ignored); 1 uses bits [5:0]; 2 and 3 use all 8 bits. Unused bits are stored as zero. The masked code is compared with the stored value as it is held.
- R2: In scheme 0, an arrival whose masked code differs from the stored value is accepted in that cycle. The new value can be read on `cpuMemData` from the next cycle, and the channel address is queued.
- R3: The address FIFO holds 9 entries in arrival order. `cpuFifoAddr` shows the oldest entry while `fifoEmpty` is low. `cpuRdPop` removes that entry, and a pop while the FIFO is empty has no effect.
- R4: `irq` is high exactly when the FIFO holds at least one address.
- R5: If the FIFO holds 9 entries when a change is accepted (counted before any pop in the same cycle), the address is dropped and `ovfFlag` is set. The flag stays set until reset. The control memory is still updated.
- R6: The look timer counts from 0 after reset and issues a tick in every cycle where its count equals `tickPeriod`, then restarts at 0. Ticks therefore come every `tickPeriod`+1 cycles.
- R7: In schemes 1 to 3, an arrival is a look if it comes in a tick cycle or is the first arrival of its channel since the last tick. Other arrivals are ignored.
- R8: In schemes 1 to 3, a look that differs from the stored value becomes the channel's pending candidate. It is accepted, with memory write and address queueing, only when the next look of that channel returns the same value. A differing look replaces the candidate, and a look equal to the stored value cancels it.
- R9: After reset every stored value is 0, the FIFO is empty, and `irq` and `ovfFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chValid | input | 1 | A channel code is present this cycle |
| chAddr | input | 5 | Channel address of the code |
| chData | input | 8 | Received channel code |
| scheme | input | 2 | Signaling scheme select |
| tickPeriod | input | 7 | Timer compare value for look ticks |
| cpuRdPop | input | 1 | Pop the oldest queued address |
| cpuFifoAddr | output | 5 | Oldest queued channel address |
| fifoEmpty | output | 1 | Address FIFO is empty |
| irq | output | 1 | Interrupt: changes are waiting |
| ovfFlag | output | 1 | Sticky FIFO overflow flag |
| cpuMemAddr | input | 5 | Channel whose stored value is read |
| cpuMemData | output | 8 | Stored value of that channel |

## Verification
Some rules are checked on every cycle by the assertions. The FIFO never holds more than its depth, and a pop while empty leaves it empty. A drop on a full FIFO sets the overflow flag, and the flag then stays set. Ticks are spaced as programmed. Every accepted value lands in the memory one cycle later. In the filtered schemes, every acceptance has a matching pending candidate behind it. Some behaviour only the bench scenarios can show: whether values are accepted at the right look and are not accepted early or late over long runs, the order of FIFO entries, and the field masking under each scheme. The bench checks these against a behavioural model on every clock.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic [1:0] {
    SCH_CI   = 2'd0,
    SCH_SIG6 = 2'd1,
    SCH_SIG8 = 2'd2,
    SCH_ALT8 = 2'd3
  } scheme_e;

  typedef struct packed {
    logic writeMem;
    logic loadCand;
    logic clrPend;
    logic markLook;
    logic clearLooks;
    logic push;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/sig_ctrl.sv
module sig_ctrl #(
  parameter int FIFO_DEPTH = 9,
  parameter int TIMER_W    = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          chValid,
  input  sig_pkg::scheme_e              scheme,
  input  logic [TIMER_W-1:0]            tickPeriod,
  input  logic                          cpuRdPop,
  input  logic                          eqStored,
  input  logic                          eqCand,
  input  logic                          pendBit,
  input  logic                          lookedBit,
  output sig_pkg::strobe_t              st,
  output logic [$clog2(FIFO_DEPTH)-1:0] wrPtr,
  output logic [$clog2(FIFO_DEPTH)-1:0] rdPtr,
  output logic                          fifoEmpty,
  output logic                          ovfFlag
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [TIMER_W-1:0] tmrCnt;
  logic [CNT_W-1:0]   fillCnt;
  logic               tick, sigMode, isLook, dllHit, accept;

  assign tick    = (tmrCnt == tickPeriod);
  assign sigMode = (scheme != sig_pkg::SCH_CI);
  assign isLook  = chValid && sigMode && (tick || !lookedBit);
  assign dllHit  = pendBit && eqCand;
  assign accept  = chValid && !eqStored && (sigMode ? (isLook && dllHit) : 1'b1);

  always_comb begin
    st            = '0;
    st.writeMem   = accept;
    st.loadCand   = isLook && !eqStored && !dllHit;
    st.clrPend    = isLook && (eqStored || dllHit);
    st.markLook   = chValid && sigMode;
    st.clearLooks = tick;
    st.push       = accept && (fillCnt != FULL_CNT);
    st.pop        = cpuRdPop && (fillCnt != '0);
  end

  assign fifoEmpty = (fillCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt  <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
      ovfFlag <= 1'b0;
    end else begin
      tmrCnt <= tick ? '0 : tmrCnt + 1'b1;
      if (st.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (st.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      fillCnt <= fillCnt + CNT_W'(st.push) - CNT_W'(st.pop);
      if (accept && (fillCnt == FULL_CNT)) ovfFlag <= 1'b1;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= FULL_CNT);
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdPop && fifoEmpty && !accept) |=> fifoEmpty);
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && fillCnt == FULL_CNT) |=> ovfFlag);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && tickPeriod != '0 && $stable(tickPeriod)) |=> !tick);
endmodule

// File: rtl/sig_datapath.sv
module sig_datapath #(
  parameter int NUM_CH     = 32,
  parameter int VAL_W      = 8,
  parameter int FIFO_DEPTH = 9,
  parameter int CI_W       = 4,
  parameter int SIG6_W     = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [$clog2(NUM_CH)-1:0]     chAddr,
  input  logic [VAL_W-1:0]              chData,
  input  sig_pkg::scheme_e              scheme,
  input  sig_pkg::strobe_t              st,
  input  logic [$clog2(FIFO_DEPTH)-1:0] wrPtr,
  input  logic [$clog2(FIFO_DEPTH)-1:0] rdPtr,
  input  logic [$clog2(NUM_CH)-1:0]     cpuMemAddr,
  output logic [VAL_W-1:0]              cpuMemData,
  output logic [$clog2(NUM_CH)-1:0]     headAddr,
  output logic                          eqStored,
  output logic                          eqCand,
  output logic                          pendBit,
  output logic                          lookedBit
);
  localparam int ADDR_W = $clog2(NUM_CH);

  logic [VAL_W-1:0]  ctlMem  [NUM_CH];
  logic [VAL_W-1:0]  candMem [NUM_CH];
  logic [NUM_CH-1:0] pendVec, lookedVec;
  logic [ADDR_W-1:0] addrFifo [FIFO_DEPTH];
  logic [VAL_W-1:0]  fieldMask, maskedData;
  int                fieldW;

  always_comb begin
    case (scheme)
      sig_pkg::SCH_CI:   fieldW = CI_W;
      sig_pkg::SCH_SIG6: fieldW = SIG6_W;
      default:           fieldW = VAL_W;
    endcase
    for (int i = 0; i < VAL_W; i++) fieldMask[i] = (i < fieldW);
  end

  assign maskedData = chData & fieldMask;
  assign eqStored   = (maskedData == ctlMem[chAddr]);
  assign eqCand     = (maskedData == candMem[chAddr]);
  assign pendBit    = pendVec[chAddr];
  assign lookedBit  = lookedVec[chAddr];
  assign cpuMemData = ctlMem[cpuMemAddr];
  assign headAddr   = addrFifo[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ctlMem[c]  <= '0;
        candMem[c] <= '0;
      end
      pendVec   <= '0;
      lookedVec <= '0;
    end else begin
      if (st.writeMem) ctlMem[chAddr] <= maskedData;
      if (st.loadCand) begin
        candMem[chAddr] <= maskedData;
        pendVec[chAddr] <= 1'b1;
      end
      if (st.clrPend) pendVec[chAddr] <= 1'b0;
      if (st.clearLooks) lookedVec <= '0;
      if (st.markLook) lookedVec[chAddr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.push) addrFifo[wrPtr] <= chAddr;
  end

  assert_mem_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.writeMem |=> ctlMem[$past(chAddr)] == $past(maskedData));
  assert_cand_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.loadCand |=> pendVec[$past(chAddr)]);
  assert_dll_two_looks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.writeMem && scheme != sig_pkg::SCH_CI) |-> (pendVec[chAddr] && candMem[chAddr] == maskedData));
endmodule

// File: rtl/sig_change_top.sv
module sig_change_top #(
  parameter int NUM_CH     = 32,
  parameter int VAL_W      = 8,
  parameter int FIFO_DEPTH = 9,
  parameter int TIMER_W    = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      chValid,
  input  logic [$clog2(NUM_CH)-1:0] chAddr,
  input  logic [VAL_W-1:0]          chData,
  input  logic [1:0]                scheme,
  input  logic [TIMER_W-1:0]        tickPeriod,
  input  logic                      cpuRdPop,
  output logic [$clog2(NUM_CH)-1:0] cpuFifoAddr,
  output logic                      fifoEmpty,
  output logic                      irq,
  output logic                      ovfFlag,
  input  logic [$clog2(NUM_CH)-1:0] cpuMemAddr,
  output logic [VAL_W-1:0]          cpuMemData
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  sig_pkg::scheme_e schemeSel;
  sig_pkg::strobe_t strobes;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic eqStored, eqCand, pendBit, lookedBit;

  assign schemeSel = sig_pkg::scheme_e'(scheme);
  assign irq       = !fifoEmpty;

  sig_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .TIMER_W(TIMER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chValid(chValid), .scheme(schemeSel),
    .tickPeriod(tickPeriod), .cpuRdPop(cpuRdPop), .eqStored(eqStored),
    .eqCand(eqCand), .pendBit(pendBit), .lookedBit(lookedBit), .st(strobes),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .fifoEmpty(fifoEmpty), .ovfFlag(ovfFlag)
  );

  sig_datapath #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .chAddr(chAddr), .chData(chData), .scheme(schemeSel),
    .st(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr), .cpuMemAddr(cpuMemAddr),
    .cpuMemData(cpuMemData), .headAddr(cpuFifoAddr), .eqStored(eqStored),
    .eqCand(eqCand), .pendBit(pendBit), .lookedBit(lookedBit)
  );

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && !strobes.pop) |=> irq);
endmodule

// File: tb/sim_sig_change_top.sv
module sim_sig_change_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chValid = 1'b0;
  logic [4:0] chAddr = '0;
  logic [7:0] chData = '0;
  logic [1:0] scheme = 2'd0;
  logic [6:0] tickPeriod = 7'd10;
  logic cpuRdPop = 1'b0;
  logic [4:0] cpuFifoAddr;
  logic fifoEmpty, irq, ovfFlag;
  logic [4:0] cpuMemAddr = '0;
  logic [7:0] cpuMemData;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sig_change_top u0 (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chAddr(chAddr), .chData(chData),
    .scheme(scheme), .tickPeriod(tickPeriod), .cpuRdPop(cpuRdPop),
    .cpuFifoAddr(cpuFifoAddr), .fifoEmpty(fifoEmpty), .irq(irq), .ovfFlag(ovfFlag),
    .cpuMemAddr(cpuMemAddr), .cpuMemData(cpuMemData)
  );

  // behavioural reference model
  logic [7:0] mMem [32];
  logic [7:0] mCand [32];
  bit mPend [32];
  bit mLooked [32];
  int mQ[$];
  bit mOvf;
  int mTmr;

  function automatic logic [7:0] fieldMask(input logic [1:0] s);
    if (s == 2'd0) return 8'h0F;
    if (s == 2'd1) return 8'h3F;
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 32; c++) begin
        mMem[c] = 0; mCand[c] = 0; mPend[c] = 0; mLooked[c] = 0;
      end
      mQ.delete(); mOvf = 0; mTmr = 0;
    end else begin
      bit tick, look, acc, sig, fullBefore;
      logic [7:0] m;
      tick = (mTmr == tickPeriod);
      mTmr = tick ? 0 : (mTmr + 1) % 128;
      sig = (scheme != 2'd0);
      m = chData & fieldMask(scheme);
      look = chValid && sig && (tick || !mLooked[chAddr]);
      acc = 0;
      if (chValid && !sig) acc = (m != mMem[chAddr]);
      else if (look) begin
        if (m == mMem[chAddr]) mPend[chAddr] = 0;
        else if (mPend[chAddr] && mCand[chAddr] == m) begin acc = 1; mPend[chAddr] = 0; end
        else begin mPend[chAddr] = 1; mCand[chAddr] = m; end
      end
      if (tick) for (int c = 0; c < 32; c++) mLooked[c] = 0;
      if (chValid && sig) mLooked[chAddr] = 1;
      fullBefore = (mQ.size() == 9);
      if (cpuRdPop && mQ.size() > 0) void'(mQ.pop_front());
      if (acc) begin
        mMem[chAddr] = m;
        if (fullBefore) mOvf = 1; else mQ.push_back(int'(chAddr));
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    bit mEmpty;
    mEmpty = (mQ.size() == 0);
    chk("R4 irq", irq == !mEmpty, irq, !mEmpty);
    chk("R3 fifoEmpty", fifoEmpty == mEmpty, fifoEmpty, mEmpty);
    if (!mEmpty) chk("R3 head address", cpuFifoAddr == mQ[0], cpuFifoAddr, mQ[0]);
    chk("R5 ovfFlag", ovfFlag == mOvf, ovfFlag, mOvf);
    chk("R1/R2/R6/R7/R8 stored value", cpuMemData == mMem[cpuMemAddr], cpuMemData, mMem[cpuMemAddr]);
  endtask

  task automatic step(input bit v, input int a, input int d, input bit p, input int ma);
    @(negedge clk);
    compareAll();
    chValid = v; chAddr = 5'(a); chData = 8'(d); cpuRdPop = p; cpuMemAddr = 5'(ma);
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    step(0, 0, 0, 0, a);
    #1 v = cpuMemData;
  endtask

  task automatic drain();
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, i);
    step(0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] chanVal [8];
    repeat (3) step(0, 0, 0, 0, 0);
    // R9 reset state
    chk("R9 irq after reset", irq == 0, irq, 0);
    chk("R9 fifoEmpty after reset", fifoEmpty == 1, fifoEmpty, 1);
    chk("R9 ovfFlag after reset", ovfFlag == 0, ovfFlag, 0);
    peek(7, v);
    chk("R9 memory zero", v == 0, v, 0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0);

    // R1, R2: indication scheme, immediate accept, upper bits ignored
    scheme = 2'd0;
    step(1, 3, 8'hFF, 0, 3);
    step(0, 0, 0, 0, 3);
    #1 chk("R2 immediate accept", cpuMemData == 8'h0F, cpuMemData, 8'h0F);
    chk("R3 head is channel 3", cpuFifoAddr == 3, cpuFifoAddr, 3);
    chk("R4 irq with entry", irq == 1, irq, 1);
    step(1, 3, 8'hCF, 0, 3);
    step(0, 0, 0, 1, 3);
    #1 chk("R1 D bits ignored, no second push", cpuMemData == 8'h0F, cpuMemData, 8'h0F);
    step(0, 0, 0, 0, 3);
    #1 chk("R3 pop empties", fifoEmpty == 1, fifoEmpty, 1);
    step(0, 0, 0, 1, 3);
    #1 chk("R3 pop on empty ignored", fifoEmpty == 1 && irq == 0, fifoEmpty, 1);

    // R5 overflow with 11 changes
    for (int c = 0; c < 11; c++) step(1, 8 + c, 5, 0, 18);
    step(0, 0, 0, 0, 18);
    #1 chk("R5 overflow set", ovfFlag == 1, ovfFlag, 1);
    chk("R5 memory updated on drop", cpuMemData == 8'h05, cpuMemData, 5);
    chk("R3 head oldest", cpuFifoAddr == 8, cpuFifoAddr, 8);
    drain();
    chk("R5 flag sticky after drain", ovfFlag == 1, ovfFlag, 1);

    // R7, R8: 8-bit scheme double last look
    scheme = 2'd2;
    for (int i = 0; i < 3; i++) step(1, 6, 8'h33, 0, 6);
    for (int i = 0; i < 40; i++) step(1, 6, 8'h00, 0, 6);
    #1 chk("R7 short glitch rejected", cpuMemData == 0, cpuMemData, 0);
    step(1, 5, 8'hA5, 0, 5);
    #1 chk("R8 not accepted on first look", cpuMemData == 0, cpuMemData, 0);
    for (int i = 0; i < 30; i++) step(1, 5, 8'hA5, 0, 5);
    #1 chk("R8 accepted after two looks", cpuMemData == 8'hA5, cpuMemData, 8'hA5);
    drain();

    // R1 6-bit scheme masking
    scheme = 2'd1;
    for (int i = 0; i < 30; i++) step(1, 3, 8'hFF, 0, 3);
    #1 chk("R1 six bit field", cpuMemData == 8'h3F, cpuMemData, 8'h3F);
    drain();

    // random runs in each scheme, checked against the model each cycle
    for (int s = 0; s < 4; s++) begin
      scheme = 2'(s);
      for (int c = 0; c < 8; c++) chanVal[c] = 8'($urandom);
      for (int i = 0; i < 4000; i++) begin
        int a;
        a = $urandom_range(0, 7);
        if ($urandom_range(0, 63) == 0) chanVal[a] = 8'($urandom);
        step($urandom_range(0, 3) != 0, a,
             ($urandom_range(0, 15) == 0) ? int'($urandom) : int'(chanVal[a]),
             $urandom_range(0, 7) == 0, $urandom_range(0, 31));
      end
      drain();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule